// File: doc/BRIEF.md
# Row-Stationary Convolution PE Array

This block computes a two-dimensional convolution of a single input channel. It does so by cutting the work into one-dimensional row primitives. The array holds one processing element (PE) for each pair of kernel row and output row. Each PE slides one kernel row across one input row, with stride 1, and produces one row of partial sums. The partial sums of every PE that serves the same output row are added column by column, and the result is one complete output row.

Kernel weights are loaded as a stream. Each kernel row is delivered at the same time to every PE in the matching array row, so weights are shared horizontally. Input pixels are also loaded as a stream. Each input row is delivered at the same time to every PE on the matching anti-diagonal, so pixels are shared diagonally. Each PE keeps what it receives in small local buffers that fill in arrival order. A start pulse then runs all PEs in lockstep, with one multiply and one add per PE per cycle. For every output column, the results of all output rows are presented together on one wide bus with a single strobe. A done flag follows the last column.

With defaults: input W=8 columns by H=6 rows, kernel S=3 columns by R=3 rows. This gives E=H-R+1=4 output rows and F=W-S+1=6 output columns.

Top module: `rs_conv_array`

## Requirements
- R1: The PE at kernel row j and output row e computes, for each output column c in 0..F-1, the sum over k in 0..S-1 of weight(j,k)×pixel(e+j,c+k). It uses exactly S multiply-accumulate cycles per column.
- R2: Output element (e,c) is the sum, over j in 0..R-1, of the column-c partial sum of PE (j,e). Lane e of `outData` occupies bits [32e+31:32e].
- R3: Products are signed 16×16 bits and sums are 32 bits. Overflow wraps modulo 2^32 with no saturation.
- R4: Weights enter on `wtData` while `wtValid` is high, in row-major order (kernel row 0 first, column 0 first within a row), R×S words in all. Kernel row j is written into every PE whose array row is j.
- R5: Pixels enter on `pxData` while `pxValid` is high, in row-major order, H×W words in all. Input row i is written into every PE (j,e) with j+e=i.
- R6: The clock edge that samples an accepted start is edge 0. The result of column c then appears for exactly one cycle after edge c·S+S+1, with `outValid` high and `outCol`=c. All E lanes are valid together, and columns appear in ascending order.
- R7: While a computation runs, `start`, `wtValid` and `pxValid` are ignored. The running results do not change, and the stored weights and pixels are not modified.
- R8: `done` is cleared by an accepted start. It rises one cycle after the `outValid` of the last column and stays high until the next accepted start.
- R9: After reset, `outValid` and `done` are low.
- R10: An accepted start rewinds both load pointers, so the next weight word goes to row 0 column 0 and the next pixel word goes to row 0 column 0. A load pointer also wraps to 0 after a complete set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; accepted only when idle |
| wtValid | input | 1 | Weight word strobe |
| wtData | input | 16 | Signed weight word |
| pxValid | input | 1 | Pixel word strobe |
| pxData | input | 16 | Signed pixel word |
| outValid | output | 1 | One-cycle strobe per completed output column |
| outCol | output | 8 | Output column index of the current strobe |
| outData | output | 32·E | E signed 32-bit output elements, lane e = output row e |
| done | output | 1 | Sticky completion flag |

## Verification
The bench uses asymmetric weights and pixels. A design that swaps the diagonal pixel mapping, or indexes the wrong kernel row, therefore gives wrong values in specific lanes. Full-scale negative operands drive the 32-bit sum through wrap-around, which shows any saturation or width truncation. Start and load strobes are injected in the middle of a run, and the run is then repeated without reloading. A design that restarts, or that writes its buffers during a run, would shift the strobe timing or change the second run's results. A partial load followed by a start checks that the pointers rewind; a design that forgets to rewind would put the next full load in the wrong places.

// File: rtl/rs_conv_pkg.sv
package rs_conv_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             wtWe;
    logic [IDX_W-1:0] wtRow;
    logic [IDX_W-1:0] wtCol;
    logic             pxWe;
    logic [IDX_W-1:0] pxRow;
    logic [IDX_W-1:0] pxCol;
    logic             mac;
    logic             clear;
    logic [IDX_W-1:0] tap;
    logic [IDX_W-1:0] col;
    logic             emit;
    logic [IDX_W-1:0] emitCol;
  } rsCtrl_t;
endpackage

// File: rtl/rs_pe.sv
module rs_pe #(
  parameter int IN_W = 8,
  parameter int K_S  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wtWe,
  input  logic [7:0]         wtIdx,
  input  logic signed [15:0] wtData,
  input  logic               pxWe,
  input  logic [7:0]         pxIdx,
  input  logic signed [15:0] pxData,
  input  logic               mac,
  input  logic               clear,
  input  logic [7:0]         tap,
  input  logic [7:0]         col,
  output logic signed [31:0] acc
);
  localparam int TW = (K_S > 1) ? $clog2(K_S) : 1;
  localparam int XW = (IN_W > 1) ? $clog2(IN_W) : 1;

  logic signed [15:0] wBuf [K_S];
  logic signed [15:0] xBuf [IN_W];
  logic [7:0]         xIdx;
  logic signed [31:0] prod;

  assign xIdx = col + tap;
  assign prod = wBuf[tap[TW-1:0]] * xBuf[xIdx[XW-1:0]];

  always_ff @(posedge clk) begin
    if (wtWe) wBuf[wtIdx[TW-1:0]] <= wtData;
    if (pxWe) xBuf[pxIdx[XW-1:0]] <= pxData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)    acc <= '0;
    else if (mac) acc <= clear ? prod : acc + prod;
  end
endmodule

// File: rtl/rs_conv_ctrl.sv
module rs_conv_ctrl
  import rs_conv_pkg::*;
#(
  parameter int IN_W = 8,
  parameter int IN_H = 6,
  parameter int K_R  = 3,
  parameter int K_S  = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    wtValid,
  input  logic    pxValid,
  output rsCtrl_t ctl,
  output logic    done
);
  localparam int OUT_W = IN_W - K_S + 1;
  localparam logic [7:0] TAP_LAST = 8'(K_S - 1);
  localparam logic [7:0] COL_LAST = 8'(OUT_W - 1);
  localparam logic [7:0] KS_LAST  = 8'(K_S - 1);
  localparam logic [7:0] KR_LAST  = 8'(K_R - 1);
  localparam logic [7:0] W_LAST   = 8'(IN_W - 1);
  localparam logic [7:0] H_LAST   = 8'(IN_H - 1);

  logic       run, emitQ, lastQ, doneArm;
  logic [7:0] tapCnt, colCnt, emitColQ;
  logic [7:0] wRow, wCol, pRow, pCol;
  logic       accept, kLast, cLast, wtWe, pxWe;

  assign accept = start && !run;
  assign kLast  = (tapCnt == TAP_LAST);
  assign cLast  = (colCnt == COL_LAST);
  assign wtWe   = wtValid && !run && !start;
  assign pxWe   = pxValid && !run && !start;

  always_comb begin
    ctl.wtWe    = wtWe;
    ctl.wtRow   = wRow;
    ctl.wtCol   = wCol;
    ctl.pxWe    = pxWe;
    ctl.pxRow   = pRow;
    ctl.pxCol   = pCol;
    ctl.mac     = run;
    ctl.clear   = (tapCnt == 8'd0);
    ctl.tap     = tapCnt;
    ctl.col     = colCnt;
    ctl.emit    = emitQ;
    ctl.emitCol = emitColQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      run <= 1'b0; tapCnt <= '0; colCnt <= '0; emitQ <= 1'b0; emitColQ <= '0;
      lastQ <= 1'b0; doneArm <= 1'b0; done <= 1'b0;
      wRow <= '0; wCol <= '0; pRow <= '0; pCol <= '0;
    end else begin
      emitQ   <= run && kLast;
      lastQ   <= run && kLast && cLast;
      doneArm <= lastQ;
      if (run && kLast) emitColQ <= colCnt;
      if (accept) begin
        run <= 1'b1; tapCnt <= '0; colCnt <= '0; done <= 1'b0;
        lastQ <= 1'b0; doneArm <= 1'b0;
        wRow <= '0; wCol <= '0; pRow <= '0; pCol <= '0;
      end else begin
        if (doneArm) done <= 1'b1;
        if (run) begin
          if (kLast) begin
            tapCnt <= '0;
            if (cLast) run <= 1'b0;
            else       colCnt <= colCnt + 8'd1;
          end else begin
            tapCnt <= tapCnt + 8'd1;
          end
        end
        if (wtWe) begin
          if (wCol == KS_LAST) begin
            wCol <= '0;
            wRow <= (wRow == KR_LAST) ? 8'd0 : wRow + 8'd1;
          end else wCol <= wCol + 8'd1;
        end
        if (pxWe) begin
          if (pCol == W_LAST) begin
            pCol <= '0;
            pRow <= (pRow == H_LAST) ? 8'd0 : pRow + 8'd1;
          end else pCol <= pCol + 8'd1;
        end
      end
    end
  end

  // R1: the tap counter never leaves the kernel row
  assert_tap_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (tapCnt <= TAP_LAST));
  // R7: a running computation steps on, whatever start does
  assert_run_steps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (run && !kLast) |=> (run && tapCnt == $past(tapCnt) + 8'd1));
  // R8: done holds until a start arrives
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);
  // R8: an accepted start clears done
  assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !done);
endmodule

// File: rtl/rs_conv_datapath.sv
module rs_conv_datapath
  import rs_conv_pkg::*;
#(
  parameter int IN_W = 8,
  parameter int IN_H = 6,
  parameter int K_R  = 3,
  parameter int K_S  = 3,
  localparam int OUT_H = IN_H - K_R + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  rsCtrl_t            ctl,
  input  logic signed [15:0] wtData,
  input  logic signed [15:0] pxData,
  output logic               outValid,
  output logic [7:0]         outCol,
  output logic [OUT_H*32-1:0] outData
);
  logic signed [31:0] accs   [K_R][OUT_H];
  logic signed [31:0] rowSum [OUT_H];

  for (genvar j = 0; j < K_R; j++) begin : gRow
    for (genvar e = 0; e < OUT_H; e++) begin : gCol
      rs_pe #(.IN_W(IN_W), .K_S(K_S)) pe (
        .clk(clk), .rstN(rstN),
        .wtWe(ctl.wtWe && ctl.wtRow == 8'(j)), .wtIdx(ctl.wtCol), .wtData(wtData),
        .pxWe(ctl.pxWe && ctl.pxRow == 8'(j + e)), .pxIdx(ctl.pxCol), .pxData(pxData),
        .mac(ctl.mac), .clear(ctl.clear), .tap(ctl.tap), .col(ctl.col),
        .acc(accs[j][e])
      );
    end
  end

  for (genvar e = 0; e < OUT_H; e++) begin : gSum
    always_comb begin
      rowSum[e] = '0;
      for (int j = 0; j < K_R; j++) rowSum[e] = rowSum[e] + accs[j][e];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outCol   <= '0;
      outData  <= '0;
    end else begin
      outValid <= ctl.emit;
      if (ctl.emit) begin
        outCol <= ctl.emitCol;
        for (int e = 0; e < OUT_H; e++) outData[e*32 +: 32] <= rowSum[e];
      end
    end
  end

  // R6: a completed column is presented on the next cycle
  assert_emit_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emit |=> outValid);
  // R6: strobes are S cycles apart, never back to back
  if (K_S > 1) begin : gGap
    assert_strobe_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
      outValid |=> !outValid);
  end
endmodule

// File: rtl/rs_conv_array.sv
module rs_conv_array
  import rs_conv_pkg::*;
#(
  parameter int IN_W = 8,
  parameter int IN_H = 6,
  parameter int K_R  = 3,
  parameter int K_S  = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic                          wtValid,
  input  logic signed [15:0]            wtData,
  input  logic                          pxValid,
  input  logic signed [15:0]            pxData,
  output logic                          outValid,
  output logic [7:0]                    outCol,
  output logic [(IN_H-K_R+1)*32-1:0]    outData,
  output logic                          done
);
  rsCtrl_t ctl;

  rs_conv_ctrl #(.IN_W(IN_W), .IN_H(IN_H), .K_R(K_R), .K_S(K_S)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .wtValid(wtValid), .pxValid(pxValid),
    .ctl(ctl), .done(done)
  );

  rs_conv_datapath #(.IN_W(IN_W), .IN_H(IN_H), .K_R(K_R), .K_S(K_S)) dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wtData(wtData), .pxData(pxData),
    .outValid(outValid), .outCol(outCol), .outData(outData)
  );
endmodule

// File: tb/tb_rs_conv_array.sv
module tb_rs_conv_array;
  localparam int W = 8, H = 6, R = 3, S = 3;
  localparam int E = H - R + 1, F = W - S + 1;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic wtValid = 1'b0, pxValid = 1'b0;
  logic signed [15:0] wtData = '0, pxData = '0;
  logic outValid, done;
  logic [7:0] outCol;
  logic [E*32-1:0] outData;

  int vectors = 0, miscompares = 0;
  logic signed [15:0] wm [R][S];
  logic signed [15:0] xm [H][W];
  logic signed [31:0] expv [E][F];

  always #10 clk = ~clk;

  rs_conv_array #(.IN_W(W), .IN_H(H), .K_R(R), .K_S(S)) dut (
    .clk(clk), .rstN(rstN), .start(start), .wtValid(wtValid), .wtData(wtData),
    .pxValid(pxValid), .pxData(pxData), .outValid(outValid), .outCol(outCol),
    .outData(outData), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void computeExp();
    for (int e = 0; e < E; e++)
      for (int c = 0; c < F; c++) begin
        logic signed [31:0] s;
        s = '0;
        for (int j = 0; j < R; j++)
          for (int k = 0; k < S; k++) s = s + wm[j][k] * xm[e+j][c+k];
        expv[e][c] = s;
      end
  endfunction

  task automatic loadAll();
    for (int j = 0; j < R; j++)
      for (int k = 0; k < S; k++) begin
        @(negedge clk); wtValid = 1'b1; wtData = wm[j][k];
      end
    @(negedge clk); wtValid = 1'b0;
    for (int i = 0; i < H; i++)
      for (int c = 0; c < W; c++) begin
        @(negedge clk); pxValid = 1'b1; pxData = xm[i][c];
      end
    @(negedge clk); pxValid = 1'b0;
  endtask

  // Runs one computation and compares outputs every cycle (R6 timing, R8 done).
  task automatic runCheck(input string dataReq, input bit inject);
    computeExp();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int cyc = 1; cyc <= F * S + 5; cyc++) begin
      bit expValid;
      int col;
      col = (cyc - S - 2) / S;
      expValid = (cyc >= S + 2) && ((cyc - S - 2) % S == 0) && (col < F);
      check("R6 outValid", {31'd0, outValid}, {31'd0, expValid});
      check("R8 done", {31'd0, done}, {31'd0, (cyc >= F * S + 3)});
      if (expValid) begin
        check("R6 outCol", {24'd0, outCol}, 32'(col));
        for (int e = 0; e < E; e++) check(dataReq, outData[e*32 +: 32], expv[e][col]);
      end
      if (inject && cyc == 3) begin
        start = 1'b1; wtValid = 1'b1; wtData = 16'h7abc; pxValid = 1'b1; pxData = 16'h1357;
      end
      if (inject && cyc == 5) begin
        start = 1'b0; wtValid = 1'b0; pxValid = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 outValid", {31'd0, outValid}, 32'd0);
    check("R9 done", {31'd0, done}, 32'd0);
    rstN = 1'b1;

    // R1 R4 R5: asymmetric data exposes row and diagonal mapping
    for (int j = 0; j < R; j++)
      for (int k = 0; k < S; k++) wm[j][k] = 16'(j * 5 - k * 3 + 2);
    for (int i = 0; i < H; i++)
      for (int c = 0; c < W; c++) xm[i][c] = 16'(i * 11 - c * 7 + 3 + (i * c) % 5);
    loadAll();
    runCheck("R1 R2 R4 R5 data", 1'b0);

    // R7: strobes injected mid-run, then a rerun with no reload
    runCheck("R7 data with injected strobes", 1'b1);
    runCheck("R7 data after ignored loads", 1'b0);

    // R3: full-scale operands force wrap-around of the 32-bit sum
    for (int j = 0; j < R; j++)
      for (int k = 0; k < S; k++) wm[j][k] = -16'sd32768;
    for (int i = 0; i < H; i++)
      for (int c = 0; c < W; c++) xm[i][c] = (c % 2 == 0) ? -16'sd32768 : 16'sd32767;
    loadAll();
    runCheck("R3 wrap data", 1'b0);

    // R10: partial load, then start rewinds the pointer
    @(negedge clk); wtValid = 1'b1; wtData = 16'sd9;  wm[0][0] = 16'sd9;
    @(negedge clk); wtValid = 1'b1; wtData = -16'sd4; wm[0][1] = -16'sd4;
    @(negedge clk); wtValid = 1'b0;
    runCheck("R10 partial load data", 1'b0);
    for (int j = 0; j < R; j++)
      for (int k = 0; k < S; k++) wm[j][k] = 16'((j + 1) * (k - 1));
    for (int i = 0; i < H; i++)
      for (int c = 0; c < W; c++) xm[i][c] = 16'(c * 13 - i * 2 - 20);
    loadAll();
    runCheck("R10 reload after rewind data", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule